// File: doc/BRIEF.md
# SD Host Slot Wrapper Register Block

This block is the shared front end of an SD host with one or two slot controllers. It sits on a 32-bit, word-only register bus that covers a 4 KiB region. The first 256 bytes hold the wrapper's own registers:

- a control/info word with a self-clearing reset request and slot-presence bits;
- a debounce setting;
- a bus setting;
- write-protect polarity;
- card detect;
- an interrupt status word.

It also holds each slot's 64-bit capability value, read and written as two 32-bit halves, and each slot's 32-bit maximum-current value.

The 256-byte pages above the wrapper area belong to the slots. Page i+1 is passed through to slot i: a select line goes high, and the read data comes from that slot's read-data bus. Any other access is refused with a one-cycle error pulse. Refused accesses are those beyond the slot pages, misaligned ones, and partial-word ones.

The per-slot interrupt inputs are watched for edges. A rising input sets its status bit and raises the merged interrupt. A falling input clears its status bit and drops the merged interrupt.

Top module: `sdhost_glue`

## Requirements
- R1: After reset, the wrapper registers read as follows:
  - word 0x00 reads 0x00010000, with bit 17 also set when NUM_SLOTS is 2;
  - word 0x04 reads 0x00000005;
  - every other plain word reads 0;
  - each slot's capability halves read the low and high halves of CAP_RESET;
  - each slot's maximum-current word reads 0.
- R2: Bit 0 of word 0x00 always reads 0. A write to word 0x00 stores every other bit as written.
- R3: Slot 0's capability low and high halves are at 0x10 and 0x14, and slot 1's are at 0x20 and 0x24. A write to one half replaces only that half, and a read returns that half.
- R4: Slot 0's maximum-current word at 0x18 and slot 1's at 0x28 are read/write 32-bit values.
- R5: Every other word offset in 0x000–0x0FC is a plain 32-bit read/write register.
- R6: Interrupt status (word 0xFC) tracks slot input edges, visible one clock after the clock edge that samples the input change:
  - a rising slot_irq[n] sets status bit n and drives irq_out high;
  - a falling slot_irq[n] clears status bit n and drives irq_out low;
  - when inputs rise and fall in the same cycle, the fall wins;
  - an input edge overrides a bus write to the same bit in the same cycle.
- R7: An access is refused when any of these holds:
  - the address lies beyond the last slot page;
  - the byte enables are not 4'b1111;
  - address bits [1:0] are not 0.

  A refused access pulses acc_err for one cycle, one cycle after the request. A refused read returns 0, and a refused write changes no register.
- R8: An accepted access to page i+1 (byte offsets (i+1)*0x100 to +0xFF) raises slot_sel[i] during the request cycle. A read there returns slot_rdata[i*32 +: 32]. Such an access raises no error and changes no wrapper register.
- R9: Every read request gets rsp_valid one cycle later, with its data on rsp_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (12) | Byte address in the region |
| req_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| acc_err | output | 1 | One-cycle pulse for a refused access |
| slot_sel | output | NUM_SLOTS | Pass-through select per slot page |
| slot_rdata | input | 32*NUM_SLOTS | Read data from each slot |
| slot_irq | input | NUM_SLOTS | Interrupt level from each slot |
| irq_out | output | 1 | Merged interrupt |

## Verification
Wrong stored state shows at the ports only when the affected word is read back, because every register is reached through the bus. The bench therefore reads back after each write, and after each refused or pass-through access, and compares the result with its own model within two cycles. A missed or mis-timed interrupt edge shows on irq_out one cycle after the input change, and in the status word on the next read. A decode error shows at once on slot_sel, in the cycle of the request, or on acc_err in the following cycle.

// File: rtl/sdhost_glue.sv
module sdhost_glue #(
  parameter int          NUM_SLOTS = 2,
  parameter int          AW        = 12,
  parameter logic [63:0] CAP_RESET = 64'h0000_0007_01F8_0080
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AW-1:0]          req_addr,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   acc_err,
  output logic [NUM_SLOTS-1:0]   slot_sel,
  input  logic [32*NUM_SLOTS-1:0] slot_rdata,
  input  logic [NUM_SLOTS-1:0]   slot_irq,
  output logic                   irq_out
);
  localparam int          GWORDS   = 64;
  localparam int          SW       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int          STAT_IDX = GWORDS - 1;
  localparam logic [31:0] INFO_RST = 32'h0001_0000 | ((NUM_SLOTS >= 2) ? 32'h0002_0000 : 32'h0);
  localparam logic [31:0] DEB_RST  = 32'h0000_0005;

  logic [AW-9:0]        page;
  logic [5:0]           widx;
  logic                 acc_ok, in_glob, slot_hit, bad, wr_g, win_hit;
  logic [SW-1:0]        win_slot;
  logic [1:0]           win_fld;
  logic [31:0]          gr   [GWORDS];
  logic [63:0]          cap  [NUM_SLOTS];
  logic [31:0]          maxc [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] irq_q, rise, fall;
  logic [31:0]          rd_mux;

  assign page     = req_addr[AW-1:8];
  assign widx     = req_addr[7:2];
  assign acc_ok   = req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00;
  assign in_glob  = page == '0;
  assign win_fld  = widx[1:0];
  assign win_hit  = in_glob && widx[5:2] >= 4'd1 && 32'(widx[5:2]) <= NUM_SLOTS && win_fld != 2'd3;
  assign win_slot = SW'(widx[5:2] - 4'd1);
  assign slot_hit = |slot_sel;
  assign bad      = req_valid && !(acc_ok && (in_glob || slot_hit));
  assign wr_g     = acc_ok && req_write && in_glob;
  assign rise     = slot_irq & ~irq_q;
  assign fall     = ~slot_irq & irq_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_sel
    assign slot_sel[s] = acc_ok && 32'(page) == s + 1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < GWORDS; k++) gr[k] <= '0;
      gr[0] <= INFO_RST;
      gr[1] <= DEB_RST;
    end else begin
      if (wr_g && !win_hit)
        gr[widx] <= (widx == 6'd0) ? (req_wdata & ~32'h1) : req_wdata;
      for (int n = 0; n < NUM_SLOTS; n++) begin
        if (rise[n]) gr[STAT_IDX][n] <= 1'b1;
        if (fall[n]) gr[STAT_IDX][n] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        cap[s]  <= CAP_RESET;
        maxc[s] <= '0;
      end
    end else if (wr_g && win_hit) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (win_slot == SW'(s)) begin
          case (win_fld)
            2'd0:    cap[s][31:0]  <= req_wdata;
            2'd1:    cap[s][63:32] <= req_wdata;
            default: maxc[s]       <= req_wdata;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      irq_q <= slot_irq;
      if (|fall)      irq_out <= 1'b0;
      else if (|rise) irq_out <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = gr[widx];
    if (slot_hit) begin
      rd_mux = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
        if (slot_sel[s]) rd_mux = slot_rdata[s*32 +: 32];
    end else if (win_hit) begin
      rd_mux = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (win_slot == SW'(s)) begin
          case (win_fld)
            2'd0:    rd_mux = cap[s][31:0];
            2'd1:    rd_mux = cap[s][63:32];
            default: rd_mux = maxc[s];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      acc_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      acc_err   <= bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? rd_mux : 32'h0;
    end
  end
endmodule

// File: rtl/sdhost_glue_chk.sv
module sdhost_glue_chk #(
  parameter int NUM_SLOTS = 2,
  parameter int AW        = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_write,
  input logic [AW-1:0]           req_addr,
  input logic [3:0]              req_be,
  input logic                    rsp_valid,
  input logic [31:0]             rsp_rdata,
  input logic                    acc_err,
  input logic [NUM_SLOTS-1:0]    slot_sel,
  input logic [NUM_SLOTS-1:0]    slot_irq,
  input logic                    irq_out
);
  logic fine;
  assign fine = req_be == 4'hF && req_addr[1:0] == 2'b00 &&
                32'(req_addr[AW-1:8]) <= NUM_SLOTS;

  // R7
  oob_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !fine |=> acc_err);
  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && fine |=> !acc_err);
  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err && rsp_valid |-> rsp_rdata == 32'h0);
  // R9
  rd_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rsp_valid);
  // R8
  sel_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));
  // R8
  sel_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |slot_sel |-> req_valid && fine);
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(~slot_irq & $past(slot_irq)) |=> !irq_out);
  // R2
  info_b0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && req_addr == '0 |=> !rsp_rdata[0]);
endmodule

bind sdhost_glue sdhost_glue_chk #(.NUM_SLOTS(NUM_SLOTS), .AW(AW)) chk_i (.*);

// File: tb/sdhost_glue_tb.sv
module sdhost_glue_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NS   = 2;
  localparam logic [63:0] CAPR = 64'h0000_0007_01F8_0080;
  localparam logic [31:0] SD0  = 32'hA0A0_5500;
  localparam logic [31:0] SD1  = 32'hB1B1_66FF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, acc_err, irq_out;
  logic [31:0] rsp_rdata;
  logic [NS-1:0] slot_sel;
  logic [NS-1:0] slot_irq = 0;
  logic [32*NS-1:0] slot_rdata = {SD1, SD0};

  int errs = 0, checks = 0;
  bit done = 0;
  logic [31:0] mg [64];
  logic [63:0] mcap [NS];
  logic [31:0] mmax [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  sdhost_glue #(.NUM_SLOTS(NS), .AW(12), .CAP_RESET(CAPR)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [11:0] a, input logic [3:0] be);
    return be != 4'hF || a[1:0] != 0 || a[11:8] > NS;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    int w = int'(a[7:2]);
    if (a[11:8] == 1) return SD0;
    if (a[11:8] == 2) return SD1;
    if (w == 4)  return mcap[0][31:0];
    if (w == 5)  return mcap[0][63:32];
    if (w == 6)  return mmax[0];
    if (w == 8)  return mcap[1][31:0];
    if (w == 9)  return mcap[1][63:32];
    if (w == 10) return mmax[1];
    return mg[w];
  endfunction

  task automatic mdl_wr(input logic [11:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (a[11:8] != 0) return;
    case (w)
      0:  mg[0] = d & ~32'h1;
      4:  mcap[0][31:0] = d;
      5:  mcap[0][63:32] = d;
      6:  mmax[0] = d;
      8:  mcap[1][31:0] = d;
      9:  mcap[1][63:32] = d;
      10: mmax[1] = d;
      default: mg[w] = d;
    endcase
  endtask

  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d, input logic [3:0] be,
                     output logic [31:0] rd, output logic er, output logic rv);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd = rsp_rdata; er = acc_err; rv = rsp_valid;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic e, v;
    acc(1, a, d, 4'hF, r, e, v);
    if (!is_bad(a, 4'hF)) mdl_wr(a, d);
  endtask

  task automatic rd_chk(input logic [11:0] a, input string tag);
    logic [31:0] r; logic e, v;
    logic [31:0] x = exp_rd(a);
    acc(0, a, 0, 4'hF, r, e, v);
    chk(r == x && v && !e, tag, r, x);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; logic e, v;
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 64; k++) mg[k] = 0;
    mg[0] = 32'h0003_0000; mg[1] = 32'h5;
    for (int s = 0; s < NS; s++) begin mcap[s] = CAPR; mmax[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    chk(!acc_err && !irq_out && !rsp_valid, "R1 outputs", {29'b0, acc_err, irq_out, rsp_valid}, 0);
    rd_chk(12'h000, "R1 info");
    rd_chk(12'h004, "R1 debounce");
    rd_chk(12'h008, "R1 bus");
    rd_chk(12'h0EC, "R1 wp");
    rd_chk(12'h0F0, "R1 cd");
    rd_chk(12'h0FC, "R1 stat");
    rd_chk(12'h010, "R1 cap0 lo");
    rd_chk(12'h014, "R1 cap0 hi");
    rd_chk(12'h018, "R1 max0");
    rd_chk(12'h020, "R1 cap1 lo");
    rd_chk(12'h024, "R1 cap1 hi");
    rd_chk(12'h028, "R1 max1");

    // R2 self-clearing bit 0
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk(12'h000, "R2 info b0");

    // R3 capability halves
    wr(12'h010, 32'hDEAD_0001);
    rd_chk(12'h014, "R3 cap0 hi kept");
    rd_chk(12'h010, "R3 cap0 lo");
    wr(12'h024, 32'h1234_5678);
    rd_chk(12'h020, "R3 cap1 lo kept");
    rd_chk(12'h024, "R3 cap1 hi");
    rd_chk(12'h014, "R3 cap0 untouched");

    // R4 max current
    wr(12'h018, 32'h0000_00C8);
    wr(12'h028, 32'h0000_0190);
    rd_chk(12'h018, "R4 max0");
    rd_chk(12'h028, "R4 max1");

    // R5 plain registers
    wr(12'h0EC, 32'hCAFE_F00D);
    wr(12'h02C, 32'h0BAD_BEEF);
    rd_chk(12'h0EC, "R5 wp");
    rd_chk(12'h02C, "R5 spare");

    // R7 refused accesses
    acc(1, 12'h3EC, 32'h1111_1111, 4'hF, r, e, v);
    chk(e == 1, "R7 oob write err", {31'b0, e}, 1);
    rd_chk(12'h0EC, "R7 oob write ignored");
    acc(1, 12'h008, 32'h7777_7777, 4'h3, r, e, v);
    chk(e == 1, "R7 partial write err", {31'b0, e}, 1);
    rd_chk(12'h008, "R7 partial write ignored");
    acc(0, 12'hFFC, 0, 4'hF, r, e, v);
    chk(e && v && r == 0, "R7 oob read zero", r, 0);
    acc(0, 12'h0EE, 0, 4'hF, r, e, v);
    chk(e && r == 0, "R7 misaligned read", r, 0);
    @(negedge clk);
    chk(acc_err == 0, "R7 err single pulse", {31'b0, acc_err}, 0);

    // R8 pass-through
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 12'h204; req_be = 4'hF;
    #1 chk(slot_sel == 2'b10, "R8 sel slot1", {30'b0, slot_sel}, 2);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_rdata == SD1 && !acc_err && rsp_valid, "R8 slot1 data", rsp_rdata, SD1);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 12'h1EC; req_wdata = 32'h9999_9999;
    #1 chk(slot_sel == 2'b01, "R8 sel slot0", {30'b0, slot_sel}, 1);
    @(negedge clk);
    req_valid = 0; req_write = 0;
    chk(!acc_err, "R8 no err", {31'b0, acc_err}, 0);
    rd_chk(12'h0EC, "R8 global untouched");
    rd_chk(12'h100, "R9 slot0 read");

    // R6 interrupt merge
    @(negedge clk); slot_irq = 2'b01;
    @(negedge clk);
    chk(irq_out == 1, "R6 rise raises", {31'b0, irq_out}, 1);
    mg[63][0] = 1;
    rd_chk(12'h0FC, "R6 stat bit0");
    @(negedge clk); slot_irq = 2'b11;
    @(negedge clk);
    chk(irq_out == 1, "R6 second rise", {31'b0, irq_out}, 1);
    mg[63][1] = 1;
    rd_chk(12'h0FC, "R6 stat both");
    @(negedge clk); slot_irq = 2'b10;
    @(negedge clk);
    chk(irq_out == 0, "R6 fall drops", {31'b0, irq_out}, 0);
    mg[63][0] = 0;
    rd_chk(12'h0FC, "R6 stat bit1 only");
    @(negedge clk); slot_irq = 2'b00;
    @(negedge clk);
    mg[63][1] = 0;
    rd_chk(12'h0FC, "R6 stat clear");

    // R5 R7 R9 random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [3:0] be;
      logic [31:0] d, x;
      bit w;
      bit bd;
      a  = ($urandom % 10 == 0) ? 12'(12'h300 + ($urandom % 12'hD00)) : 12'(($urandom % 64) * 4);
      be = ($urandom % 8 == 0) ? 4'($urandom % 15) : 4'hF;
      d  = $urandom;
      w  = 1'($urandom % 2);
      bd = is_bad(a, be);
      x  = bd ? 32'h0 : exp_rd(a);
      acc(w, a, d, be, r, e, v);
      chk(e == bd, "R7 rand err", {31'b0, e}, {31'b0, bd});
      if (!w) chk(v && r == x, "R9 rand read", r, x);
      else if (!bd) mdl_wr(a, d);
    end
    for (int k = 0; k < 64; k++) rd_chk(12'(k * 4), "R5 final sweep");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule